// File: doc/BRIEF.md
# Cause-Mask Interrupt Aggregator

The block gathers up to 32 level-sensitive interrupt request lines into one interrupt output for a downstream interrupt controller. Each request line sets a sticky bit in a cause register. An enable register selects which cause bits may raise the output. Software reads the cause register to find which sources fired and writes ones to it to acknowledge them. It sets and clears enables with read-modify-write on the enable register.

A combinational status output gives software or a small sequencer the lowest-numbered source that is both latched and enabled, without a scan of the registers. The register port is a plain 32-bit word bus with a byte address, a write strobe, write data and combinational read data. Bit i of every register word belongs to source i.

Top module: `irq_aggr`

## Requirements
- R1: After reset the cause register and the enable register both read 0, irq_o is low and status_o is 0.
- R2: A request line that is high at a rising clock edge sets its cause bit at that edge. The cause register reads back at byte offset 0x0, with bit i standing for source i.
- R3: A write to offset 0x0 clears every cause bit whose write-data bit is 1 and leaves every bit written with 0 unchanged.
- R4: When a request is high in the same cycle as an acknowledge of its bit, the bit stays set. A request held high re-latches after every acknowledge.
- R5: A write to offset 0x4 replaces the enable register with the write data. The register reads back exactly what was written and holds its value when it is not written.
- R6: Writes to any offset other than 0x0 and 0x4 change neither register. Reads of those offsets return 0.
- R7: irq_o is registered. It is high in the cycle after (cause AND enable) is nonzero, and low in the cycle after that set becomes zero.
- R8: status_o[5] is 1 exactly when (cause AND enable) is nonzero. status_o[4:0] then holds the index of its lowest set bit, and holds 0 when status_o[5] is 0.
- R9: With no request high, writing 0 to offset 0x4 and then all ones to offset 0x0 leaves both registers at 0, status_o at 0 and irq_o low.
- R10: A source whose enable bit is 0 still latches into the cause register but affects neither irq_o nor status_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Level request lines, bit i is source i |
| addr_i | input | 4 | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, combinational on addr_i |
| irq_o | output | 1 | Aggregated interrupt, registered |
| status_o | output | 6 | {valid, index of lowest pending enabled source} |

## Verification
Several rules are checked on every cycle against the internal cause and enable state. irq_o must follow the previous cycle's pending set. The status fields must agree with the lowest pending bit. Every request must be present in the cause register after the edge, and acknowledged bits without a request must clear. The enable register must change only on its own write and must take exactly the written value. Other behaviours show only in the bench's sweeps: the read map, the rejection of undefined offsets, the reset values, the quiesce sequence and lowest-index selection over every pair of sources.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int unsigned OFS_CAUSE = 32'h0;
  localparam int unsigned OFS_MASK  = 32'h4;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_MASK  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_aggr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(OFS_CAUSE))     sel_o = SEL_CAUSE;
    else if (addr_i == ADDR_W'(OFS_MASK)) sel_o = SEL_MASK;
    else                                  sel_o = SEL_NONE;
  end
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               ack_we_i,
  input  logic [NUM_SRC-1:0] ack_data_i,
  output logic [NUM_SRC-1:0] cause_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic bit_q;
    // request set has priority over acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      bit_q <= 1'b0;
      else if (req_i[g])                bit_q <= 1'b1;
      else if (ack_we_i && ack_data_i[g]) bit_q <= 1'b0;
    end
    assign cause_o[g] = bit_q;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] data_i,
  output logic [NUM_SRC-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (wr_i) mask_o <= data_i;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    valid_o = |pend_i;
    idx_o   = '0;
    // descending scan so the lowest set bit is written last
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (pend_i[k]) idx_o = IDX_W'(k);
    end
  end
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned STAT_W = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o,
  output logic [STAT_W-1:0]  status_o
);
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] cause_q, mask_q, pend;
  logic               pend_valid;
  logic [IDX_W-1:0]   pend_idx;

  irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  irq_cause_reg #(.NUM_SRC(NUM_SRC)) u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .ack_we_i   (we_i && (sel == SEL_CAUSE)),
    .ack_data_i (wr_data_i[NUM_SRC-1:0]),
    .cause_o    (cause_q)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i && (sel == SEL_MASK)),
    .data_i (wr_data_i[NUM_SRC-1:0]),
    .mask_o (mask_q)
  );

  assign pend = cause_q & mask_q;

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .pend_i  (pend),
    .valid_o (pend_valid),
    .idx_o   (pend_idx)
  );

  assign status_o = {pend_valid, pend_idx};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= pend_valid;
  end

  always_comb begin
    unique case (sel)
      SEL_CAUSE: rd_data_o = DATA_W'(cause_q);
      SEL_MASK:  rd_data_o = DATA_W'(mask_q);
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [NUM_SRC-1:0] cause_i,
  input logic [NUM_SRC-1:0] mask_i,
  input logic               irq_i,
  input logic [IDX_W:0]     status_i
);
  logic [NUM_SRC-1:0] pend, below, ack_eff;
  logic               wr_mask;

  assign pend    = cause_i & mask_i;
  assign below   = (NUM_SRC'(1) << status_i[IDX_W-1:0]) - NUM_SRC'(1);
  assign wr_mask = we_i && (addr_i == ADDR_W'(OFS_MASK));
  assign ack_eff = (we_i && (addr_i == ADDR_W'(OFS_CAUSE)))
                   ? (wr_data_i[NUM_SRC-1:0] & ~req_i) : '0;

  a_r7_irq_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_i == $past(|pend)));

  a_r8_valid_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[IDX_W] == (|pend));

  a_r8_lowest_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[IDX_W] |-> (pend[status_i[IDX_W-1:0]] && ((pend & below) == '0)));

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((cause_i & $past(req_i)) == $past(req_i)));

  a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((cause_i & $past(ack_eff)) == '0));

  a_r5_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_i));

  a_r5_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> (mask_i == $past(wr_data_i[NUM_SRC-1:0])));
endmodule

bind irq_aggr irq_aggr_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wr_data_i (wr_data_i),
  .cause_i   (cause_q),
  .mask_i    (mask_q),
  .irq_i     (irq_o),
  .status_i  (status_o)
);

// File: tb/irq_aggr_tb.sv
module irq_aggr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [5:0]  status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] m_cause = '0;
  logic [31:0] m_mask = '0;
  logic        m_irq = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_aggr u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .req_i     (req),
    .addr_i    (addr),
    .we_i      (we),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .irq_o     (irq),
    .status_o  (status)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // status encoding {valid, index}: lowest set bit, zero when empty
  function automatic logic [5:0] exp_status(input logic [31:0] p);
    for (int k = 0; k < 32; k++) if (p[k]) return {1'b1, 5'(k)};
    return 6'd0;
  endfunction

  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d, input logic [31:0] r);
    logic [31:0] ack, nc;
    logic ni;
    we = w; addr = a; wdata = d; req = r;
    ni  = |(m_cause & m_mask);
    ack = (w && a == 4'h0) ? d : 32'h0;
    nc  = (m_cause & ~ack) | r;
    if (w && a == 4'h4) m_mask = d;
    @(posedge clk); #1;
    m_cause = nc; m_irq = ni; we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    addr = a; #1;
    chk(rdata === e, tag, rdata, e);
  endtask

  task automatic state_chk(input string tag);
    logic [5:0] es;
    es = exp_status(m_cause & m_mask);
    rd_chk(4'h0, m_cause, {tag, " R2 cause readback"});
    rd_chk(4'h4, m_mask, {tag, " R5 mask readback"});
    chk(irq === m_irq, {tag, " R7 irq"}, 32'(irq), 32'(m_irq));
    chk(status === es, {tag, " R8 status"}, 32'(status), 32'(es));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R1: reset state
    state_chk("R1 reset");
    chk(status === 6'd0, "R1 status", 32'(status), 32'h0);

    // R2 / R10: each source latches while disabled, no irq
    for (int i = 0; i < N; i++) begin
      step(1'b0, 4'h0, 32'h0, 32'(1) << i);
      step(1'b0, 4'h0, 32'h0, 32'h0);
      state_chk($sformatf("R10 masked src %0d", i));
      chk(irq === 1'b0, "R10 no irq", 32'(irq), 32'h0);
      step(1'b1, 4'h0, 32'(1) << i, 32'h0);
      state_chk($sformatf("R3 ack src %0d", i));
    end

    // R5: mask patterns read back and hold
    for (int i = 0; i < N; i++) begin
      step(1'b1, 4'h4, ~(32'(1) << i), 32'h0);
      step(1'b0, 4'h4, 32'h0, 32'h0);
      state_chk($sformatf("R5 mask walk %0d", i));
    end

    // R8 / R7: every source pair, lowest index wins
    step(1'b1, 4'h4, 32'hFFFF_FFFF, 32'h0);
    for (int i = 0; i < N; i++) begin
      for (int j = i; j < N; j++) begin
        step(1'b0, 4'h0, 32'h0, (32'(1) << i) | (32'(1) << j));
        state_chk($sformatf("R8 pair %0d %0d", i, j));
        chk(status === {1'b1, 5'(i)}, "R8 lowest", 32'(status), 32'({1'b1, 5'(i)}));
        step(1'b1, 4'h0, 32'hFFFF_FFFF, 32'h0);
        state_chk("R7 after ack");
        chk(irq === 1'b1, "R7 irq lags clear", 32'(irq), 32'h1);
        step(1'b0, 4'h0, 32'h0, 32'h0);
        chk(irq === 1'b0, "R7 irq drops", 32'(irq), 32'h0);
      end
    end

    // R3: partial ack and write of zeros
    step(1'b0, 4'h0, 32'h0, 32'hFFFF_FFFF);
    step(1'b1, 4'h0, 32'h0000_FFFF, 32'h0);
    state_chk("R3 partial ack");
    rd_chk(4'h0, 32'hFFFF_0000, "R3 partial value");
    step(1'b1, 4'h0, 32'h0, 32'h0);
    rd_chk(4'h0, 32'hFFFF_0000, "R3 zero write no effect");

    // R4: set beats ack, held request re-latches
    step(1'b1, 4'h0, 32'hFFFF_FFFF, 32'h0000_0008);
    state_chk("R4 set wins");
    rd_chk(4'h0, 32'h0000_0008, "R4 bit kept");
    step(1'b1, 4'h0, 32'h0000_0008, 32'h0000_0008);
    rd_chk(4'h0, 32'h0000_0008, "R4 relatch");
    step(1'b1, 4'h0, 32'h0000_0008, 32'h0);
    rd_chk(4'h0, 32'h0, "R4 clear after release");

    // R6: undefined offsets
    step(1'b1, 4'h4, 32'h1234_5678, 32'h0000_00F0);
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4) begin
        step(1'b1, 4'(a), 32'hFFFF_FFFF, 32'h0);
        state_chk($sformatf("R6 write ofs %0d", a));
        rd_chk(4'(a), 32'h0, "R6 read zero");
      end
    end

    // R9: quiesce
    step(1'b0, 4'h0, 32'h0, 32'hA5A5_A5A5);
    step(1'b1, 4'h4, 32'h0, 32'h0);
    step(1'b1, 4'h0, 32'hFFFF_FFFF, 32'h0);
    step(1'b0, 4'h0, 32'h0, 32'h0);
    state_chk("R9 quiesce");
    chk(irq === 1'b0 && status === 6'd0, "R9 quiet", {25'h0, irq, status}, 32'h0);
    rd_chk(4'h0, 32'h0, "R9 cause zero");

    finish_run();
  end
endmodule